// File: doc/BRIEF.md
# Warp Bank Conflict Degree Evaluator

This block takes the byte addresses that one warp presents to a banked scratchpad in a single cycle. It translates each active lane's address into a bank number and a layer (row) within that bank. From that it works out how many serialized passes the scratchpad would need. Lanes that touch the same layer of the same bank merge into one access. Lanes that touch different layers of one bank serialize. The largest number of distinct layers asked of any single bank is the conflict degree. The block reports that degree, the replay count that follows from it, and the lowest-numbered bank that reaches it.

The address translation is chosen per request by two select bits, a bank-width mode and an element size. Three combinations are supported:
- narrow banks with narrow elements, a row-major split;
- wide banks with narrow elements, where pairs of neighbours share a layer;
- wide banks with wide elements, the plain low-order interleave.

Every bank layer is 8 bytes wide. One layer across all banks spans 256 bytes.

The request side is a valid/ready stream. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result is registered and shows up with `out_valid` on the next cycle. `in_ready` is high whenever the output register is empty or is being drained (`out_ready` high) in the same cycle. While `out_valid` is high and `out_ready` is low, the result holds steady and no new request is taken.

Top module: `wbc_conflict_eval`

## Requirements
- R1: With `bank_mode`=0 (4-byte banks) and `elem_size`=0 (4-byte elements), a lane's bank is address bits [6:2] and its layer is the address divided by 256.
- R2: With `bank_mode`=1 (8-byte banks) and `elem_size`=0, a lane's bank is address bits [7:3] and its layer is the address divided by 256, so odd element strides can conflict.
- R3: With `bank_mode`=1 and `elem_size`=1 (8-byte elements), bank and layer are as in R2. A constant element stride S from offset 0 over 32 lanes gives degree gcd(S,32).
- R4: Any number of active lanes that share both bank and layer add exactly one to that bank's count.
- R5: Lanes whose `in_mask` bit is 0 take no part. With an all-zero mask, degree, replays and worst bank are all 0.
- R6: `out_degree` is the maximum over banks of that bank's distinct-layer count. `out_worst_bank` is the lowest bank index that reaches this maximum (0 when the degree is 0).
- R7: `out_replays` equals `out_degree` minus one, and is 0 when the degree is 0.
- R8: The combination `bank_mode`=0 with `elem_size`=1 is unsupported. It sets `out_error` to 1 with degree, replays and worst bank all 0. Supported combinations give `out_error`=0.
- R9: After reset `out_valid` is 0 and `in_ready` is 1. An accepted request produces `out_valid`=1 with its result on the following cycle.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all result outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | LANES*ADDR_W (512) | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| in_mask | input | LANES (32) | Active-lane mask, bit i for lane i |
| bank_mode | input | 1 | 0: 4-byte bank access, 1: 8-byte bank access |
| elem_size | input | 1 | 0: 4-byte elements, 1: 8-byte elements |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_degree | output | 6 | Conflict degree |
| out_replays | output | 6 | Replay cycles, degree minus one |
| out_worst_bank | output | 5 | Lowest bank reaching the degree |
| out_error | output | 1 | Unsupported mode/size combination |

## Verification
The main sweep drives full warps at every element stride from 1 to 64 from four base offsets, in each of the three supported mappings. This separates the mappings from one another: odd strides conflict only in the paired-element mapping. It also shows the row-major case gaining a degree from an unaligned base. The wide-element sweep is compared against gcd(S,32) as well as the bank-by-bank model, so a wrong bank slice shows up even where both models could agree.

Pseudo-random masks with scattered addresses exercise the lane-exclusion rule and the tie-breaking towards the lowest bank. Hand-built patterns isolate several cases:
- merging within one layer;
- a deliberate two-bank tie;
- an empty mask;
- the unsupported combination.

A stalled-consumer sequence shows that results hold and that new requests are refused until the output drains.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  // Address-to-bank translation chosen by the mode/size selects
  typedef enum logic [1:0] {
    MAP_ROW  = 2'd0,  // 4-byte banks, 4-byte elements
    MAP_PAIR = 2'd1,  // 8-byte banks, 4-byte elements
    MAP_WIDE = 2'd2,  // 8-byte banks, 8-byte elements
    MAP_BAD  = 2'd3   // unsupported combination
  } map_kind_e;

  function automatic map_kind_e decode_map(input logic wide_banks, input logic wide_elems);
    map_kind_e k;
    case ({wide_banks, wide_elems})
      2'b00:   k = MAP_ROW;
      2'b10:   k = MAP_PAIR;
      2'b11:   k = MAP_WIDE;
      default: k = MAP_BAD;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/wbc_lane_map.sv
module wbc_lane_map
  import wbc_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int ADDR_W  = 16,
  parameter int BANK_W  = 5,
  parameter int LAYER_W = 8
) (
  input  logic [LANES*ADDR_W-1:0]  addr_flat,
  input  map_kind_e                kind,
  output logic [LANES*BANK_W-1:0]  bank_flat,
  output logic [LANES*LAYER_W-1:0] layer_flat
);

  localparam int LAYER_LSB = BANK_W + 3;  // 8-byte layer times bank count

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ADDR_W-1:0] a;
    assign a = addr_flat[i*ADDR_W +: ADDR_W];

    always_comb begin
      if (kind == MAP_ROW) begin
        bank_flat[i*BANK_W +: BANK_W] = a[BANK_W+1:2];
      end else begin
        bank_flat[i*BANK_W +: BANK_W] = a[BANK_W+2:3];
      end
      layer_flat[i*LAYER_W +: LAYER_W] = a[ADDR_W-1:LAYER_LSB];
    end
  end

endmodule

// File: rtl/wbc_first_detect.sv
module wbc_first_detect #(
  parameter int LANES   = 32,
  parameter int BANK_W  = 5,
  parameter int LAYER_W = 8
) (
  input  logic [LANES*BANK_W-1:0]  bank_flat,
  input  logic [LANES*LAYER_W-1:0] layer_flat,
  input  logic [LANES-1:0]         mask,
  output logic [LANES-1:0]         first
);

  // A lane counts only if no lower active lane already claimed its bank layer
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic dup;
    always_comb begin
      dup = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (mask[j] &&
            bank_flat[j*BANK_W +: BANK_W] == bank_flat[i*BANK_W +: BANK_W] &&
            layer_flat[j*LAYER_W +: LAYER_W] == layer_flat[i*LAYER_W +: LAYER_W]) begin
          dup = 1'b1;
        end
      end
      first[i] = mask[i] && !dup;
    end
  end

endmodule

// File: rtl/wbc_bank_count.sv
module wbc_bank_count #(
  parameter int LANES    = 32,
  parameter int BANK_CNT = 32,
  parameter int BANK_W   = 5,
  parameter int CNT_W    = 6
) (
  input  logic [LANES*BANK_W-1:0]   bank_flat,
  input  logic [LANES-1:0]          first,
  output logic [BANK_CNT*CNT_W-1:0] cnt_flat
);

  for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
    logic [CNT_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int l = 0; l < LANES; l++) begin
        cnt = cnt + CNT_W'(first[l] && (bank_flat[l*BANK_W +: BANK_W] == BANK_W'(b)));
      end
    end
    assign cnt_flat[b*CNT_W +: CNT_W] = cnt;
  end

endmodule

// File: rtl/wbc_max_pick.sv
module wbc_max_pick #(
  parameter int BANK_CNT = 32,
  parameter int BANK_W   = 5,
  parameter int CNT_W    = 6
) (
  input  logic [BANK_CNT*CNT_W-1:0] cnt_flat,
  output logic [CNT_W-1:0]          max_cnt,
  output logic [BANK_W-1:0]         max_idx
);

  // Strictly-greater replacement keeps the lowest index on ties
  always_comb begin
    max_cnt = cnt_flat[CNT_W-1:0];
    max_idx = '0;
    for (int b = 1; b < BANK_CNT; b++) begin
      if (cnt_flat[b*CNT_W +: CNT_W] > max_cnt) begin
        max_cnt = cnt_flat[b*CNT_W +: CNT_W];
        max_idx = BANK_W'(b);
      end
    end
  end

endmodule

// File: rtl/wbc_conflict_eval.sv
module wbc_conflict_eval
  import wbc_pkg::*;
#(
  parameter int LANES    = 32,
  parameter int BANK_CNT = 32,
  parameter int ADDR_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]        in_mask,
  input  logic                    bank_mode,
  input  logic                    elem_size,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [$clog2(LANES+1)-1:0] out_degree,
  output logic [$clog2(LANES+1)-1:0] out_replays,
  output logic [$clog2(BANK_CNT)-1:0] out_worst_bank,
  output logic                    out_error
);

  localparam int BANK_W  = $clog2(BANK_CNT);
  localparam int CNT_W   = $clog2(LANES+1);
  localparam int LAYER_W = ADDR_W - BANK_W - 3;

  map_kind_e                kind;
  logic [LANES-1:0]         eff_mask;
  logic [LANES*BANK_W-1:0]  bank_flat;
  logic [LANES*LAYER_W-1:0] layer_flat;
  logic [LANES-1:0]         first;
  logic [BANK_CNT*CNT_W-1:0] cnt_flat;
  logic [CNT_W-1:0]         max_cnt;
  logic [BANK_W-1:0]        max_idx;
  logic                     accept;

  assign kind     = decode_map(bank_mode, elem_size);
  assign eff_mask = (kind == MAP_BAD) ? '0 : in_mask;

  wbc_lane_map #(.LANES(LANES), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .LAYER_W(LAYER_W)) u_map (
    .addr_flat (in_addr),
    .kind      (kind),
    .bank_flat (bank_flat),
    .layer_flat(layer_flat)
  );

  wbc_first_detect #(.LANES(LANES), .BANK_W(BANK_W), .LAYER_W(LAYER_W)) u_first (
    .bank_flat (bank_flat),
    .layer_flat(layer_flat),
    .mask      (eff_mask),
    .first     (first)
  );

  wbc_bank_count #(.LANES(LANES), .BANK_CNT(BANK_CNT), .BANK_W(BANK_W), .CNT_W(CNT_W)) u_count (
    .bank_flat(bank_flat),
    .first    (first),
    .cnt_flat (cnt_flat)
  );

  wbc_max_pick #(.BANK_CNT(BANK_CNT), .BANK_W(BANK_W), .CNT_W(CNT_W)) u_max (
    .cnt_flat(cnt_flat),
    .max_cnt (max_cnt),
    .max_idx (max_idx)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_degree     <= '0;
      out_replays    <= '0;
      out_worst_bank <= '0;
      out_error      <= 1'b0;
    end else if (accept) begin
      out_valid      <= 1'b1;
      out_degree     <= max_cnt;
      out_replays    <= (max_cnt == '0) ? '0 : max_cnt - CNT_W'(1);
      out_worst_bank <= max_idx;
      out_error      <= (kind == MAP_BAD);
    end else if (out_ready) begin
      out_valid      <= 1'b0;
    end
  end

endmodule

// File: rtl/wbc_conflict_eval_chk.sv
module wbc_conflict_eval_chk #(
  parameter int LANES    = 32,
  parameter int BANK_CNT = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [LANES-1:0]           in_mask,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [$clog2(LANES+1)-1:0] out_degree,
  input logic [$clog2(LANES+1)-1:0] out_replays,
  input logic [$clog2(BANK_CNT)-1:0] out_worst_bank,
  input logic                       out_error
);

  localparam int CNT_W = $clog2(LANES+1);

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);  // R9

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);  // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_degree) && $stable(out_replays)
      && $stable(out_worst_bank) && $stable(out_error));  // R10

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);  // R10

  AST_DEGREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_degree <= CNT_W'($countones($past(in_mask))));  // R5

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mask == '0 |=> out_degree == '0 && out_worst_bank == '0);  // R5

  AST_REPLAY_REL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_degree != '0 |-> out_replays + CNT_W'(1) == out_degree);  // R7

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_error |-> out_degree == '0 && out_replays == '0);  // R8

endmodule

bind wbc_conflict_eval wbc_conflict_eval_chk #(.LANES(LANES), .BANK_CNT(BANK_CNT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_mask       (in_mask),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_degree    (out_degree),
  .out_replays   (out_replays),
  .out_worst_bank(out_worst_bank),
  .out_error     (out_error)
);

// File: tb/tb_wbc_conflict_eval.sv
module tb_wbc_conflict_eval;

  localparam int LANES = 32;
  localparam int AW    = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [LANES*AW-1:0] in_addr = '0;
  logic [LANES-1:0] in_mask = '0;
  logic            bank_mode = 1'b0;
  logic            elem_size = 1'b0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [5:0]      out_degree;
  logic [5:0]      out_replays;
  logic [4:0]      out_worst_bank;
  logic            out_error;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  logic [AW-1:0] a_addr [LANES];
  int exp_deg, exp_worst, exp_err;

  always #5 clk = ~clk;

  wbc_conflict_eval dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_mask(in_mask), .bank_mode(bank_mode), .elem_size(elem_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_degree(out_degree),
    .out_replays(out_replays), .out_worst_bank(out_worst_bank), .out_error(out_error)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  // Bank-by-bank model with a layer occupancy bitmap
  task automatic model(input logic bm, input logic es, input logic [LANES-1:0] m);
    bit seen [32][256];
    int cnt [32];
    int bank, layer;
    for (int b = 0; b < 32; b++) begin
      cnt[b] = 0;
      for (int y = 0; y < 256; y++) seen[b][y] = 0;
    end
    exp_err = (!bm && es) ? 1 : 0;
    exp_deg = 0;
    exp_worst = 0;
    if (exp_err == 0) begin
      for (int i = 0; i < LANES; i++) begin
        if (m[i]) begin
          bank  = bm ? (int'(a_addr[i]) / 8) % 32 : (int'(a_addr[i]) / 4) % 32;
          layer = int'(a_addr[i]) / 256;
          if (!seen[bank][layer]) begin
            seen[bank][layer] = 1;
            cnt[bank]++;
          end
        end
      end
      for (int b = 0; b < 32; b++) begin
        if (cnt[b] > exp_deg) begin
          exp_deg = cnt[b];
          exp_worst = b;
        end
      end
    end
  endtask

  task automatic issue(input logic bm, input logic es, input logic [LANES-1:0] m);
    @(negedge clk);
    for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = a_addr[i];
    in_mask = m;
    bank_mode = bm;
    elem_size = es;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_case(input logic bm, input logic es, input logic [LANES-1:0] m, input string tag);
    model(bm, es, m);
    issue(bm, es, m);
    chk({tag, " degree"}, int'(out_degree), exp_deg);
    chk({tag, "/R6 worst bank"}, int'(out_worst_bank), exp_worst);
    chk({tag, "/R7 replays"}, int'(out_replays), (exp_deg == 0) ? 0 : exp_deg - 1);
    chk({tag, "/R8 error"}, int'(out_error), exp_err);
    chk({tag, "/R9 out_valid"}, int'(out_valid), 1);
  endtask

  function automatic int gcd32(input int s);
    int a = s;
    int b = 32;
    int t;
    while (b != 0) begin
      t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  initial begin
    int offs [4];
    logic [31:0] lfsr;
    offs[0] = 0; offs[1] = 4; offs[2] = 136; offs[3] = 252;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset out_valid", int'(out_valid), 0);
    chk("R9 reset in_ready", int'(in_ready), 1);
    rst_n = 1'b1;

    // Stride sweep across supported mappings
    for (int md = 0; md < 3; md++) begin
      for (int s = 1; s <= 64; s++) begin
        for (int o = 0; o < 4; o++) begin
          int esz;
          esz = (md == 2) ? 8 : 4;
          for (int i = 0; i < LANES; i++) a_addr[i] = AW'(offs[o] + i * s * esz);
          case (md)
            0: run_case(1'b0, 1'b0, '1, "R1");
            1: run_case(1'b1, 1'b0, '1, "R2");
            default: begin
              run_case(1'b1, 1'b1, '1, "R3");
              if (o == 0) chk("R3 gcd degree", int'(out_degree), gcd32(s));
            end
          endcase
        end
      end
    end

    // R4: neighbouring words share one wide layer
    for (int i = 0; i < LANES; i++) a_addr[i] = AW'(i * 4);
    issue(1'b1, 1'b0, '1);
    chk("R4 shared layer degree", int'(out_degree), 1);
    for (int i = 0; i < LANES; i++) a_addr[i] = AW'(1024);
    issue(1'b0, 1'b0, '1);
    chk("R4 same address degree", int'(out_degree), 1);
    // R1: words i and i+32 share a layer in row mode
    for (int i = 0; i < LANES; i++) a_addr[i] = AW'((i % 16) * 4 + ((i / 16) * 128));
    issue(1'b0, 1'b0, '1);
    chk("R1 two rows one layer", int'(out_degree), 1);

    // R6: tie between bank 5 and bank 3 resolves to 3
    for (int i = 0; i < LANES; i++) a_addr[i] = '0;
    a_addr[0] = AW'(5 * 8);
    a_addr[1] = AW'(5 * 8 + 256);
    a_addr[2] = AW'(3 * 8 + 512);
    a_addr[3] = AW'(3 * 8 + 768);
    issue(1'b1, 1'b1, 32'h0000_000F);
    chk("R6 tie degree", int'(out_degree), 2);
    chk("R6 tie lowest bank", int'(out_worst_bank), 3);

    // R5: empty mask
    for (int i = 0; i < LANES; i++) a_addr[i] = AW'(i * 256);
    issue(1'b1, 1'b0, '0);
    chk("R5 empty degree", int'(out_degree), 0);
    chk("R5 empty replays", int'(out_replays), 0);
    chk("R5 empty worst", int'(out_worst_bank), 0);
    // R5: masked conflicting lanes ignored
    issue(1'b1, 1'b0, 32'h0000_0001);
    chk("R5 single active lane", int'(out_degree), 1);

    // R8: unsupported combination
    issue(1'b0, 1'b1, '1);
    chk("R8 error flag", int'(out_error), 1);
    chk("R8 error degree", int'(out_degree), 0);

    // Random masks and addresses
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 300; n++) begin
      logic [LANES-1:0] m;
      for (int i = 0; i < LANES; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        a_addr[i] = AW'(lfsr[15:0] & 16'h0F3C);
      end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      m = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      run_case(lfsr[3], lfsr[3] ? lfsr[5] : 1'b0, m, "R5");
    end

    // R10: back-pressure
    for (int i = 0; i < LANES; i++) a_addr[i] = AW'(i * 16);
    out_ready = 1'b0;
    issue(1'b1, 1'b1, '1);
    chk("R10 first result degree", int'(out_degree), 2);
    @(negedge clk);
    for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = AW'(i * 8);
    in_valid = 1'b1;
    #1;
    chk("R10 in_ready low while stalled", int'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 held valid", int'(out_valid), 1);
    chk("R10 held degree", int'(out_degree), 2);
    out_ready = 1'b1;
    #1;
    chk("R10 in_ready after drain", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 next result degree", int'(out_degree), 1);
    @(posedge clk);
    @(negedge clk);
    chk("R9 valid drops when idle", int'(out_valid), 0);

    finish_run();
  end

endmodule